// File: doc/BRIEF.md
# Cascadable Serial Switch-Enable Register

This block is the digital control slice of a serially programmed bank of switches. A host drives a slow serial clock, a serial data line and a commit strobe. All three are oversampled by a fast system clock. Each rising edge of the serial clock shifts one bit into a staging register. A rising edge of the commit strobe copies the staging register into the output register. The output register drives the switch-enable lines, and a 1 closes a switch.

For chaining, the block produces its own outgoing serial clock. This is a fixed-width pulse issued a fixed number of system cycles after each incoming serial edge. The block also produces an outgoing data bit that changes only once that pulse has ended. An identical stage wired to these two outputs therefore samples settled data. A long chain is programmed as one serial stream carrying four bits per stage, followed by a single commit that reaches every stage.

Top module: `serial_switch_chain`

## Requirements
- R1: Each rising edge of `serClk` shifts `serData` into the staging register. Both inputs pass through the same synchronizer depth, so the bit shifted in is the one present at the serial edge.
- R2: Bits are sent MSB-first. Of the last four bits before a commit, the first lands on `swEnable[3]` and the last lands on `swEnable[0]`.
- R3: On the cascade pulse issued for serial edge k, `cascadeData` holds the bit shifted in at serial edge k-4. It holds 0 when fewer than four bits have arrived since reset.
- R4: Shifting never changes `swEnable`. The outputs keep their committed value until the next commit.
- R5: A rising edge of `commitStrobe` loads `swEnable` with the staging register as it stands.
- R6: Reset (`rstN` low, asynchronous) clears `swEnable`, the staging register, `cascadeClk` and `cascadeData` to 0.
- R7: For each serial rising edge, `cascadeClk` goes high 3 + PULSE_DELAY system cycles after the `serClk` input rises: two cycles for synchronizing, one for edge detection. It stays high for exactly PULSE_WIDTH cycles, whatever the width of the `serClk` high phase.
- R8: `cascadeData` is stable while `cascadeClk` is high. It takes its new value in the cycle the pulse falls, and that value is the top staging bit after the latest shift.
- R9: A commit issued after reset with no shifting leaves every switch open.
- R10: Holding `commitStrobe` high produces one commit only. Bits shifted while it stays high do not reach `swEnable` until the strobe goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Incoming serial clock (asynchronous) |
| serData | input | 1 | Incoming serial data (asynchronous) |
| commitStrobe | input | 1 | Commit strobe; rising edge updates outputs |
| swEnable | output | NUM_SW | Switch enables, 1 = closed |
| cascadeClk | output | 1 | Regenerated fixed-width clock for the next stage |
| cascadeData | output | 1 | Delayed data for the next stage |

## Verification
The bench builds the block with its defaults: four switches, two synchronizer stages, a pulse delay of 2 and a pulse width of 2. This makes the cascade pulse and the data update fall inside a serial period of only a few system cycles. With these values, the onset cycle, the width and the data change of each pulse can be checked at exact sample points. Serial high phases of 2 and 8 cycles show that the pulse width does not follow the input. Streams longer than four bits show the four-edge delay on the cascade output.

// File: rtl/swchain_pkg.sv
package swchain_pkg;
  typedef struct packed {
    logic shift;     // serial clock rising edge seen
    logic shiftBit;  // synchronized data bit to shift in
    logic commit;    // commit strobe rising edge seen
    logic outUpd;    // cascade pulse finished: refresh data out
  } chainStrobes_t;
endpackage

// File: rtl/sw_chain_ctrl.sv
module sw_chain_ctrl
  import swchain_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_DELAY = 2,
  parameter int PULSE_WIDTH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serClkIn,
  input  logic          serDataIn,
  input  logic          commitIn,
  output chainStrobes_t strobes,
  output logic          pulseOut
);
  localparam int NUM_IN = 3;
  localparam int TOTAL = PULSE_DELAY + PULSE_WIDTH;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] DELAY_C = CNT_W'(PULSE_DELAY);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [NUM_IN-1:0] rawIn;
  logic [SYNC_STAGES-1:0][NUM_IN-1:0] syncQ;
  logic [NUM_IN-1:0] syncOut, prevQ;
  logic clkRise, commitRise;
  logic [CNT_W-1:0] cnt, cntNext;
  logic cntDone, pulseQ;

  assign rawIn = {commitIn, serDataIn, serClkIn};

  // synchronizer chain, all inputs share the same depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      prevQ <= syncOut;
    end
  end

  assign syncOut    = syncQ[SYNC_STAGES-1];
  assign clkRise    = syncOut[0] & ~prevQ[0];
  assign commitRise = syncOut[2] & ~prevQ[2];
  assign cntDone    = (cnt == TOTAL_C);

  // pulse timer: 1..TOTAL, high during (DELAY, TOTAL]
  always_comb begin
    if (clkRise)        cntNext = ONE_C;
    else if (cntDone)   cntNext = '0;
    else if (cnt != '0) cntNext = cnt + ONE_C;
    else                cntNext = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pulseQ <= 1'b0;
    end else begin
      cnt    <= cntNext;
      pulseQ <= (cntNext > DELAY_C);
    end
  end

  assign pulseOut         = pulseQ;
  assign strobes.shift    = clkRise;
  assign strobes.shiftBit = syncOut[1];
  assign strobes.commit   = commitRise;
  assign strobes.outUpd   = cntDone;
endmodule

// File: rtl/sw_chain_datapath.sv
module sw_chain_datapath
  import swchain_pkg::*;
#(
  parameter int NUM_SW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobes_t     strobes,
  output logic [NUM_SW-1:0] primaryOut,
  output logic [NUM_SW-1:0] swEnable,
  output logic              dataOut
);
  logic [NUM_SW-1:0] primaryQ, secondaryQ;
  logic dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primaryQ   <= '0;
      secondaryQ <= '0;
      dataQ      <= 1'b0;
    end else begin
      if (strobes.shift)  primaryQ   <= {primaryQ[NUM_SW-2:0], strobes.shiftBit};
      if (strobes.commit) secondaryQ <= primaryQ;
      if (strobes.outUpd) dataQ      <= primaryQ[NUM_SW-1];
    end
  end

  assign primaryOut = primaryQ;
  assign swEnable   = secondaryQ;
  assign dataOut    = dataQ;
endmodule

// File: rtl/serial_switch_chain.sv
module serial_switch_chain
  import swchain_pkg::*;
#(
  parameter int NUM_SW      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_DELAY = 2,
  parameter int PULSE_WIDTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              commitStrobe,
  output logic [NUM_SW-1:0] swEnable,
  output logic              cascadeClk,
  output logic              cascadeData
);
  chainStrobes_t strobes;
  logic [NUM_SW-1:0] primaryQ;

  sw_chain_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .PULSE_DELAY(PULSE_DELAY),
    .PULSE_WIDTH(PULSE_WIDTH)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .serClkIn(serClk), .serDataIn(serData), .commitIn(commitStrobe),
    .strobes(strobes), .pulseOut(cascadeClk)
  );

  sw_chain_datapath #(.NUM_SW(NUM_SW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .primaryOut(primaryQ), .swEnable(swEnable), .dataOut(cascadeData)
  );
endmodule

module serial_switch_chain_chk
  import swchain_pkg::*;
#(
  parameter int NUM_SW      = 4,
  parameter int PULSE_WIDTH = 2
) (
  input logic              clk,
  input logic              rstN,
  input chainStrobes_t     strobes,
  input logic [NUM_SW-1:0] primary,
  input logic [NUM_SW-1:0] swEnable,
  input logic              cascadeClk,
  input logic              cascadeData
);
  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else       runLen <= cascadeClk ? runLen + 1 : 0;
  end

  a_r6_reset_open: assert property (@(posedge clk)
    !rstN |-> (swEnable == '0 && !cascadeClk && !cascadeData));

  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> primary == {$past(primary[NUM_SW-2:0]), $past(strobes.shiftBit)});

  a_r4_hold_until_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(swEnable));

  a_r5_commit_copy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> swEnable == $past(primary));

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (!cascadeClk && $past(cascadeClk)) |-> runLen == PULSE_WIDTH);

  a_r8_data_stable_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cascadeClk |-> $stable(cascadeData));

  a_r8_data_only_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.outUpd |=> $stable(cascadeData));
endmodule

bind serial_switch_chain serial_switch_chain_chk #(
  .NUM_SW(NUM_SW), .PULSE_WIDTH(PULSE_WIDTH)
) uChk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .primary(primaryQ),
  .swEnable(swEnable), .cascadeClk(cascadeClk), .cascadeData(cascadeData)
);

// File: tb/tb_serial_switch_chain.sv
module tb_serial_switch_chain;
  localparam int NUM_SW = 4;
  localparam int PULSE_DELAY = 2;
  localparam int PULSE_WIDTH = 2;
  localparam int ONSET = 3 + PULSE_DELAY;
  localparam int AFTER = ONSET + PULSE_WIDTH;
  localparam int NVEC = 6;
  // each entry: {word, serial high cycles}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'hA, 8'd2}, {4'h5, 8'd8}, {4'hF, 8'd2},
    {4'h0, 8'd8}, {4'h9, 8'd3}, {4'h6, 8'd6}
  };

  logic clk = 0, rstN = 0, serClk = 0, serData = 0, commitStrobe = 0;
  logic [NUM_SW-1:0] swEnable;
  logic cascadeClk, cascadeData;
  int nChecks = 0, nFail = 0;
  logic [NUM_SW-1:0] model = '0;

  always #5 clk = ~clk;

  serial_switch_chain #(.NUM_SW(NUM_SW), .PULSE_DELAY(PULSE_DELAY),
                        .PULSE_WIDTH(PULSE_WIDTH)) dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .commitStrobe(commitStrobe), .swEnable(swEnable),
    .cascadeClk(cascadeClk), .cascadeData(cascadeData));

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input int hi);
    int onset = -1;
    int width = 0;
    logic dOn = 0, dLast = 0, dAfter = 0;
    @(negedge clk);
    serData = b;
    serClk = 1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (cascadeClk) begin
        if (onset < 0) begin onset = i; dOn = cascadeData; end
        width++;
        dLast = cascadeData;
      end
      if (i == AFTER) dAfter = cascadeData;
      if (i == hi) serClk = 0;
    end
    chk("R7 pulse onset", onset, ONSET);
    chk("R7 pulse width", width, PULSE_WIDTH);
    chk("R3 data four edges back", int'(dOn), int'(model[NUM_SW-1]));
    chk("R8 data stable in pulse", int'(dLast), int'(dOn));
    model = {model[NUM_SW-2:0], b};
    chk("R8 data after pulse", int'(dAfter), int'(model[NUM_SW-1]));
  endtask

  task automatic sendWord(input logic [3:0] w, input int hi);
    for (int i = 3; i >= 0; i--) sendBit(w[i], hi);
  endtask

  task automatic pulseCommit(input logic holdHigh);
    @(negedge clk);
    commitStrobe = 1;
    repeat (6) @(negedge clk);
    if (!holdHigh) commitStrobe = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [3:0] prevWord;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 swEnable reset", int'(swEnable), 0);
    chk("R6 cascadeClk reset", int'(cascadeClk), 0);
    chk("R6 cascadeData reset", int'(cascadeData), 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R9: commit with nothing shifted keeps switches open
    pulseCommit(1'b0);
    chk("R9 commit after reset", int'(swEnable), 0);

    // table walk: R1, R2, R4, R5
    prevWord = 4'h0;
    for (int v = 0; v < NVEC; v++) begin
      sendWord(VEC[v][11:8], int'(VEC[v][7:0]));
      chk("R4 no change before commit", int'(swEnable), int'(prevWord));
      pulseCommit(1'b0);
      chk("R5 R2 R1 committed word", int'(swEnable), int'(VEC[v][11:8]));
      prevWord = VEC[v][11:8];
    end

    // R10: strobe held high commits once
    sendWord(4'hC, 4);
    pulseCommit(1'b1);
    chk("R10 first commit", int'(swEnable), 12);
    sendWord(4'h3, 4);
    repeat (6) @(negedge clk);
    chk("R10 held strobe no recommit", int'(swEnable), 12);
    commitStrobe = 0;
    repeat (4) @(negedge clk);
    pulseCommit(1'b0);
    chk("R10 new rise commits", int'(swEnable), 3);

    // R6: reset mid-operation clears everything including staging
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    chk("R6 swEnable after reset", int'(swEnable), 0);
    chk("R6 cascadeData after reset", int'(cascadeData), 0);
    rstN = 1;
    model = '0;
    repeat (3) @(negedge clk);
    pulseCommit(1'b0);
    chk("R6 staging cleared", int'(swEnable), 0);
    sendBit(1'b1, 2);
    sendBit(1'b0, 2);
    pulseCommit(1'b0);
    chk("R2 partial stream LSBs", int'(swEnable), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule